// File: doc/BRIEF.md
# NAND Sector Hamming Parity Accumulator

This block builds a single-error-correcting parity code over one 512-byte NAND sector while the bytes stream past on an 8-bit bus. It keeps one accumulator per chip select, four in all. Each accumulator is idle after reset. It takes bytes only after software has started it, and only while its own chip select is the active one. Every accepted byte folds into two 12-bit parity fields that are indexed by the bit position inside the sector.

Reading an accumulator returns its raw parity word. The same read clears that accumulator and puts it back to idle. A separate checker compares a stored 24-bit code with a freshly computed one. One cycle later it reports whether the data is clean, holds a single flipped bit that can be corrected (with the byte and bit position), has an error only in the stored code, or cannot be corrected.

Top module: `nand_ecc_unit`

## Requirements
- R1: After reset every accumulator reads back as zero and is idle, and `chk_valid` is low.
- R2: Number each data bit of the sector by p = byte_index*8 + bit_index (12 bits). Bit k of the "set" field is the XOR of all data bits whose p has bit k set. Bit k of the "clear" field is the XOR of all data bits whose p has bit k clear.
- R3: A byte with `byte_valid` high updates only the accumulator that `cs_sel` names, and only if that accumulator has been started. All other accumulators keep their contents.
- R4: `rd_word` shows the accumulator named by `rd_cs`. The clear field sits in bits [11:0] and the set field in bits [27:16]. Bits [15:12] and [31:28] are zero.
- R5: In the cycle where `rd_req` is high, `rd_word` still shows the value before the clear. At the next edge that accumulator is cleared to zero and made idle, so it ignores further bytes until it is started again.
- R6: An accumulator counts its accepted bytes and takes no more than 512. Bytes beyond the 512th leave it unchanged.
- R7: A `start_mask` bit in the same cycle as a read-clear of the same accumulator leaves it zeroed and running. The next bytes then accumulate from an empty state.
- R8: With diff = stored XOR calc over 24 bits, a zero diff gives status 0 (clean), with byte and bit outputs zero.
- R9: If diff[23:12] XOR diff[11:0] is all ones, the status is 1 (correctable). `chk_byte` is diff[23:15] and `chk_bit` is diff[14:12]. If that byte index is 512 or more, the status is 3 instead.
- R10: A diff with exactly one bit set that is not correctable gives status 2 (error in the stored code), with byte and bit outputs zero.
- R11: Any other nonzero diff gives status 3 (uncorrectable), with byte and bit outputs zero.
- R12: The checker result and `chk_valid` appear one clock after `chk_req`. `chk_valid` is high for exactly one cycle per request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_sel | input | 2 | Chip select whose accumulator may take the current byte |
| byte_valid | input | 1 | A data byte is on `byte_data` this cycle |
| byte_data | input | 8 | Data byte |
| start_mask | input | 4 | One bit per chip select; a high bit starts that accumulator |
| rd_req | input | 1 | Read-clear of the accumulator named by `rd_cs` |
| rd_cs | input | 2 | Accumulator shown on `rd_word` |
| rd_word | output | 32 | Raw parity word of the selected accumulator |
| chk_req | input | 1 | Compare request |
| chk_stored | input | 24 | Code read back from the flash |
| chk_calc | input | 24 | Code computed over the data just read |
| chk_valid | output | 1 | Checker result valid (one cycle after request) |
| chk_status | output | 2 | 0 clean, 1 correctable, 2 code error, 3 uncorrectable |
| chk_byte | output | 9 | Failing byte index when correctable |
| chk_bit | output | 3 | Failing bit index when correctable |

## Verification
The bench computes parity over generated sectors with its own bit-position model. It compares against lanes that were started, lanes that were never started, and lanes fed while another chip select owned the bus, so a design that leaked bytes into the wrong lane, or accepted bytes before a start, gives a nonzero word where zero is expected. A run of 520 bytes catches a counter that wraps or does not saturate: such a design folds the extra bytes back in at index 0 and differs from the 512-byte model. Read-clear is checked for the value it returns, the zero it leaves, and the idle state after it, and a start in the same cycle as the clear must leave the lane running from empty. The checker table includes the index-extreme correctable cases (byte 0 bit 0, byte 511 bit 7), single-bit diffs in either half, and nonzero code pairs, so a wrong field split, a wrong priority or a wrong index shift shows up as a wrong status or position.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    // Result of comparing a stored code with a freshly computed one
    typedef enum logic [1:0] {
        CHK_CLEAN = 2'd0,
        CHK_FIX   = 2'd1,
        CHK_CODE  = 2'd2,
        CHK_FATAL = 2'd3
    } chk_status_e;

    // Bits needed to address a bit inside one byte
    localparam int unsigned SUBBIT_W = 3;

endpackage

// File: rtl/ecc_lane.sv
module ecc_lane #(
    parameter int unsigned SECTOR_BYTES = 512
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       byte_en,
    input  logic [7:0]                                 byte_in,
    input  logic                                       start_i,
    input  logic                                       clear_i,
    output logic [$clog2(SECTOR_BYTES)+nand_ecc_pkg::SUBBIT_W-1:0] hi_o,
    output logic [$clog2(SECTOR_BYTES)+nand_ecc_pkg::SUBBIT_W-1:0] lo_o,
    output logic                                       running_o
);
    import nand_ecc_pkg::*;

    localparam int unsigned IDX_W   = $clog2(SECTOR_BYTES);
    localparam int unsigned FIELD_W = IDX_W + SUBBIT_W;
    localparam int unsigned CNT_W   = IDX_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SECTOR_BYTES);

    typedef struct packed {
        logic               run;
        logic [CNT_W-1:0]   cnt;
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } lane_t;

    lane_t lane_d, lane_q;

    logic [FIELD_W-1:0] hi_delta;
    logic [FIELD_W-1:0] lo_delta;
    logic [IDX_W-1:0]   byte_idx;
    logic               byte_par;
    logic               accept;

    // Per-byte contribution to both parity fields
    always_comb begin
        byte_idx = lane_q.cnt[IDX_W-1:0];
        byte_par = ^byte_in;
        hi_delta = '0;
        lo_delta = '0;
        for (int k = 0; k < int'(SUBBIT_W); k++) begin
            for (int j = 0; j < 8; j++) begin
                if (((j >> k) & 1) != 0) hi_delta[k] = hi_delta[k] ^ byte_in[j];
                else                     lo_delta[k] = lo_delta[k] ^ byte_in[j];
            end
        end
        for (int k = int'(SUBBIT_W); k < int'(FIELD_W); k++) begin
            hi_delta[k] = byte_par &  byte_idx[k-SUBBIT_W];
            lo_delta[k] = byte_par & ~byte_idx[k-SUBBIT_W];
        end
    end

    // Next-state computation
    always_comb begin
        lane_d = lane_q;
        accept = lane_q.run && byte_en && (lane_q.cnt < CNT_MAX) && !clear_i;
        if (accept) begin
            lane_d.hi  = lane_q.hi ^ hi_delta;
            lane_d.lo  = lane_q.lo ^ lo_delta;
            lane_d.cnt = lane_q.cnt + 1'b1;
        end
        if (clear_i) begin
            lane_d.run = 1'b0;
            lane_d.cnt = '0;
            lane_d.hi  = '0;
            lane_d.lo  = '0;
        end
        if (start_i) begin
            lane_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign hi_o      = lane_q.hi;
    assign lo_o      = lane_q.lo;
    assign running_o = lane_q.run;

    // R6: the byte count never passes the sector size
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_q.cnt <= CNT_MAX);

    // R6: a full lane keeps its parity until cleared
    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_q.cnt == CNT_MAX && !clear_i) |=> ($stable(lane_q.hi) && $stable(lane_q.lo)));

    // R3: an idle lane does not move
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lane_q.run && !clear_i) |=> ($stable(lane_q.hi) && $stable(lane_q.lo) && $stable(lane_q.cnt)));

    // R5: a clear empties and stops the lane
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !start_i) |=> (!lane_q.run && lane_q.cnt == '0 && lane_q.hi == '0 && lane_q.lo == '0));

    // R7: clear together with start leaves an empty running lane
    p_clear_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && start_i) |=> (lane_q.run && lane_q.cnt == '0 && lane_q.hi == '0));

endmodule

// File: rtl/ecc_check.sv
module ecc_check #(
    parameter int unsigned SECTOR_BYTES = 512
) (
    input  logic                                                         clk,
    input  logic                                                         rst_n,
    input  logic                                                         req_i,
    input  logic [2*($clog2(SECTOR_BYTES)+nand_ecc_pkg::SUBBIT_W)-1:0]   stored_i,
    input  logic [2*($clog2(SECTOR_BYTES)+nand_ecc_pkg::SUBBIT_W)-1:0]   calc_i,
    output logic                                                         valid_o,
    output nand_ecc_pkg::chk_status_e                                    status_o,
    output logic [$clog2(SECTOR_BYTES)-1:0]                              byte_o,
    output logic [nand_ecc_pkg::SUBBIT_W-1:0]                            bit_o
);
    import nand_ecc_pkg::*;

    localparam int unsigned IDX_W   = $clog2(SECTOR_BYTES);
    localparam int unsigned FIELD_W = IDX_W + SUBBIT_W;
    localparam int unsigned CODE_W  = 2 * FIELD_W;

    typedef struct packed {
        logic                valid;
        chk_status_e         status;
        logic [IDX_W-1:0]    byte_idx;
        logic [SUBBIT_W-1:0] bit_idx;
    } chk_t;

    chk_t chk_d, chk_q;

    logic [CODE_W-1:0]  diff;
    logic [FIELD_W-1:0] diff_hi;
    logic [FIELD_W-1:0] diff_lo;
    logic [IDX_W-1:0]   pos_byte;
    logic               one_hot;

    always_comb begin
        diff     = stored_i ^ calc_i;
        diff_hi  = diff[CODE_W-1:FIELD_W];
        diff_lo  = diff[FIELD_W-1:0];
        pos_byte = diff_hi[FIELD_W-1:SUBBIT_W];
        one_hot  = (diff & (diff - 1'b1)) == '0;

        chk_d       = chk_q;
        chk_d.valid = req_i;
        if (req_i) begin
            chk_d.byte_idx = '0;
            chk_d.bit_idx  = '0;
            if (diff == '0) begin
                chk_d.status = CHK_CLEAN;
            end else if ((diff_hi ^ diff_lo) == '1) begin
                if (int'(pos_byte) < int'(SECTOR_BYTES)) begin
                    chk_d.status   = CHK_FIX;
                    chk_d.byte_idx = pos_byte;
                    chk_d.bit_idx  = diff_hi[SUBBIT_W-1:0];
                end else begin
                    chk_d.status = CHK_FATAL;
                end
            end else if (one_hot) begin
                chk_d.status = CHK_CODE;
            end else begin
                chk_d.status = CHK_FATAL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign valid_o  = chk_q.valid;
    assign status_o = chk_q.status;
    assign byte_o   = chk_q.byte_idx;
    assign bit_o    = chk_q.bit_idx;

    // R12: a request yields a valid result on the next cycle
    p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    // R12: no request, no valid
    p_valid_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);

    // R8/R10/R11: position outputs are zero unless the error is correctable
    p_pos_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && status_o != CHK_FIX) |-> (byte_o == '0 && bit_o == '0));

endmodule

// File: rtl/nand_ecc_unit.sv
module nand_ecc_unit #(
    parameter int unsigned NUM_CS       = 4,
    parameter int unsigned SECTOR_BYTES = 512,
    parameter int unsigned WORD_W       = 32,
    parameter int unsigned HI_LSB       = 16
) (
    input  logic                                                        clk,
    input  logic                                                        rst_n,
    input  logic [$clog2(NUM_CS)-1:0]                                   cs_sel,
    input  logic                                                        byte_valid,
    input  logic [7:0]                                                  byte_data,
    input  logic [NUM_CS-1:0]                                           start_mask,
    input  logic                                                        rd_req,
    input  logic [$clog2(NUM_CS)-1:0]                                   rd_cs,
    output logic [WORD_W-1:0]                                           rd_word,
    input  logic                                                        chk_req,
    input  logic [2*($clog2(SECTOR_BYTES)+nand_ecc_pkg::SUBBIT_W)-1:0]  chk_stored,
    input  logic [2*($clog2(SECTOR_BYTES)+nand_ecc_pkg::SUBBIT_W)-1:0]  chk_calc,
    output logic                                                        chk_valid,
    output logic [1:0]                                                  chk_status,
    output logic [$clog2(SECTOR_BYTES)-1:0]                             chk_byte,
    output logic [nand_ecc_pkg::SUBBIT_W-1:0]                           chk_bit
);
    import nand_ecc_pkg::*;

    localparam int unsigned CS_W    = $clog2(NUM_CS);
    localparam int unsigned IDX_W   = $clog2(SECTOR_BYTES);
    localparam int unsigned FIELD_W = IDX_W + SUBBIT_W;

    logic [FIELD_W-1:0] hi_v  [NUM_CS];
    logic [FIELD_W-1:0] lo_v  [NUM_CS];
    logic [NUM_CS-1:0]  run_v;
    logic [NUM_CS-1:0]  lane_en;
    logic [NUM_CS-1:0]  lane_clr;

    for (genvar g = 0; g < int'(NUM_CS); g++) begin : g_lane
        assign lane_en[g]  = byte_valid && (cs_sel == CS_W'(g));
        assign lane_clr[g] = rd_req && (rd_cs == CS_W'(g));

        ecc_lane #(
            .SECTOR_BYTES (SECTOR_BYTES)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .byte_en   (lane_en[g]),
            .byte_in   (byte_data),
            .start_i   (start_mask[g]),
            .clear_i   (lane_clr[g]),
            .hi_o      (hi_v[g]),
            .lo_o      (lo_v[g]),
            .running_o (run_v[g])
        );
    end

    // Raw word: clear field low, set field at HI_LSB, spare bits zero
    always_comb begin
        rd_word                   = '0;
        rd_word[FIELD_W-1:0]      = lo_v[rd_cs];
        rd_word[HI_LSB +: FIELD_W] = hi_v[rd_cs];
    end

    chk_status_e chk_status_e_w;

    ecc_check #(
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (chk_req),
        .stored_i (chk_stored),
        .calc_i   (chk_calc),
        .valid_o  (chk_valid),
        .status_o (chk_status_e_w),
        .byte_o   (chk_byte),
        .bit_o    (chk_bit)
    );

    assign chk_status = chk_status_e_w;

    // R3: bytes for another chip select leave the displayed lane unchanged
    p_other_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && cs_sel != rd_cs && !rd_req && start_mask == '0)
            |=> ((rd_cs != $past(rd_cs)) || $stable(rd_word)));

    // R5: a lane is idle right after its read-clear unless started
    p_read_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && start_mask == '0) |=> (run_v == ($past(run_v) & ~$past(lane_clr))));

endmodule

// File: tb/tb_nand_ecc_unit.sv
`timescale 1ns/1ps
module tb_nand_ecc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cs_sel = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [3:0]  start_mask = '0;
    logic        rd_req = 1'b0;
    logic [1:0]  rd_cs = '0;
    logic [31:0] rd_word;
    logic        chk_req = 1'b0;
    logic [23:0] chk_stored = '0;
    logic [23:0] chk_calc = '0;
    logic        chk_valid;
    logic [1:0]  chk_status;
    logic [8:0]  chk_byte;
    logic [2:0]  chk_bit;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    nand_ecc_unit dut (
        .clk (clk), .rst_n (rst_n), .cs_sel (cs_sel), .byte_valid (byte_valid),
        .byte_data (byte_data), .start_mask (start_mask), .rd_req (rd_req),
        .rd_cs (rd_cs), .rd_word (rd_word), .chk_req (chk_req),
        .chk_stored (chk_stored), .chk_calc (chk_calc), .chk_valid (chk_valid),
        .chk_status (chk_status), .chk_byte (chk_byte), .chk_bit (chk_bit)
    );

    typedef struct packed {
        logic [23:0] st;
        logic [23:0] ca;
        logic [1:0]  s;
        logic [8:0]  b;
        logic [2:0]  t;
    } vec_t;

    // status: 0 clean, 1 correctable, 2 code error, 3 uncorrectable
    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{24'h000000, 24'h000000, 2'd0, 9'd0,   3'd0},  // R8
        '{24'h123456, 24'h123456, 2'd0, 9'd0,   3'd0},  // R8
        '{24'h5A3A5C, 24'h000000, 2'd1, 9'd180, 3'd3},  // R9
        '{24'hFFF000, 24'h000000, 2'd1, 9'd511, 3'd7},  // R9
        '{24'h000FFF, 24'h000000, 2'd1, 9'd0,   3'd0},  // R9
        '{24'h111111, 24'h4B2B4D, 2'd1, 9'd180, 3'd3},  // R9
        '{24'h000001, 24'h000000, 2'd2, 9'd0,   3'd0},  // R10
        '{24'h800000, 24'h000000, 2'd2, 9'd0,   3'd0},  // R10
        '{24'h0F0F0F, 24'h0F0F0E, 2'd2, 9'd0,   3'd0},  // R10
        '{24'h000003, 24'h000000, 2'd3, 9'd0,   3'd0},  // R11
        '{24'hABC543, 24'hABC000, 2'd3, 9'd0,   3'd0}   // R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_byte(input int seed, input int i);
        return 8'((i * 73 + seed * 29 + (i >> 3)) & 255);
    endfunction

    // Bench model of the raw word over the first min(n,512) bytes
    function automatic logic [31:0] model_raw(input int seed, input int n);
        logic [11:0] hi = '0;
        logic [11:0] lo = '0;
        int lim = (n < 512) ? n : 512;
        for (int i = 0; i < lim; i++) begin
            logic [7:0] b = gen_byte(seed, i);
            for (int j = 0; j < 8; j++) begin
                if (b[j]) begin
                    int p = i * 8 + j;
                    for (int k = 0; k < 12; k++) begin
                        if (((p >> k) & 1) != 0) hi[k] = ~hi[k];
                        else                     lo[k] = ~lo[k];
                    end
                end
            end
        end
        return {4'b0, hi, 4'b0, lo};
    endfunction

    task automatic feed(input logic [1:0] cs, input int seed, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cs_sel     = cs;
            byte_valid = 1'b1;
            byte_data  = gen_byte(seed, i);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        #1;
    endtask

    task automatic peek(input logic [1:0] cs, output logic [31:0] w);
        rd_cs = cs;
        #1;
        w = rd_word;
    endtask

    task automatic start(input logic [3:0] m);
        @(negedge clk);
        start_mask = m;
        @(negedge clk);
        start_mask = '0;
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        for (int c = 0; c < 4; c++) begin
            peek(2'(c), w);
            check("R1 lane zero", w, 32'h0);
        end
        check("R1 chk_valid low", {31'b0, chk_valid}, 32'h0);

        // Checker table, R8..R12
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            chk_req    = 1'b1;
            chk_stored = VECS[v].st;
            chk_calc   = VECS[v].ca;
            @(negedge clk);
            chk_req = 1'b0;
            #1;
            check("R12 valid after req", {31'b0, chk_valid}, 32'h1);
            check("R8-R11 status", {30'b0, chk_status}, {30'b0, VECS[v].s});
            check("R9 byte index", {23'b0, chk_byte}, {23'b0, VECS[v].b});
            check("R9 bit index", {29'b0, chk_bit}, {29'b0, VECS[v].t});
            @(negedge clk);
            #1;
            check("R12 valid one cycle", {31'b0, chk_valid}, 32'h0);
        end

        // R2/R4: started lane 1 accumulates
        start(4'b0010);
        feed(2'd1, 3, 40);
        peek(2'd1, w);
        check("R2 R4 lane1 parity", w, model_raw(3, 40));

        // R3: bytes for an unstarted lane, and bytes for other lanes
        feed(2'd2, 5, 16);
        peek(2'd2, w);
        check("R3 unstarted lane2", w, 32'h0);
        feed(2'd0, 7, 10);
        peek(2'd0, w);
        check("R3 unstarted lane0", w, 32'h0);
        peek(2'd1, w);
        check("R3 lane1 untouched", w, model_raw(3, 40));

        // R5: read-clear
        @(negedge clk);
        rd_cs  = 2'd1;
        rd_req = 1'b1;
        #1;
        check("R5 read returns value", rd_word, model_raw(3, 40));
        @(negedge clk);
        rd_req = 1'b0;
        #1;
        check("R5 cleared", rd_word, 32'h0);
        feed(2'd1, 3, 8);
        peek(2'd1, w);
        check("R5 idle after clear", w, 32'h0);

        // R6: saturation at 512 bytes
        start(4'b1000);
        feed(2'd3, 9, 520);
        peek(2'd3, w);
        check("R6 saturates at 512", w, model_raw(9, 512));

        // R7: start and read-clear together
        start(4'b0001);
        feed(2'd0, 11, 20);
        peek(2'd0, w);
        check("R2 lane0 parity", w, model_raw(11, 20));
        @(negedge clk);
        rd_cs      = 2'd0;
        rd_req     = 1'b1;
        start_mask = 4'b0001;
        @(negedge clk);
        rd_req     = 1'b0;
        start_mask = '0;
        feed(2'd0, 13, 6);
        peek(2'd0, w);
        check("R7 restart from empty", w, model_raw(13, 6));

        summary();
    end

endmodule